// File: doc/BRIEF.md
# DRAM Access Sequencer with Phase Stretches

This block runs a single byte access to a DRAM device through a multiplexed address bus for a simple processor bus. A request is taken only while the sequencer is idle. The access then steps through a fixed chain of phase cycles. In these cycles the block drives the row address and then the column address, lowers the row strobe and then the column strobe, and separates reads from writes with a write-enable strobe and a read strobe. On a read it captures the byte on the data bus. It ends with a one-clock done pulse.

Two optional single-cycle stretches can lengthen the access. The row stretch repeats the first phase, which keeps the row strobe high one clock longer. The cash stretch repeats the column-strobe phase, which keeps the column strobe low one clock longer. Each of two DRAM areas has its own configuration register holding the two stretch bits. An area-select input chooses which register governs an access, and the chosen bits are frozen when the request is accepted.

The states are IDLE, Q1, Q1W, Q2, Q3, Q4, Q4W and Q5. The transitions are:
- IDLE to Q1 on an accepted request.
- Q1 to Q1W if the row stretch is set, otherwise Q1 to Q2.
- Q1W to Q2.
- Q2 to Q3.
- Q3 to Q4.
- Q4 to Q4W if the column stretch is set, otherwise Q4 to Q5.
- Q4W to Q5.
- Q5 to IDLE.

Top module: `dram_seq`

## Requirements
- R1: After reset the block is idle. `busy` and `done` are 0, `ras_n`, `cas_n`, `we_n` and `rd_n` are 1, `dq_oe` is 0 and `rdata` is 0.
- R2: With both stretch bits clear, an access accepted at a clock edge occupies exactly five following cycles Q1..Q5. `done` is 1 only in Q5 and `busy` is 0 in the cycle after Q5.
- R3: `ras_n` is 1 in Q1, Q1W and Q5 and 0 in Q2, Q3, Q4 and Q4W. `cas_n` is 0 only in Q4 and Q4W. `ras_n` rises only together with `done`.
- R4: When the row stretch bit (`cfg_rasw`) of the selected area is set, Q1W is inserted directly after Q1. This makes `ras_n` high for two cycles before it falls.
- R5: When the column stretch bit (`cfg_casw`) of the selected area is set, Q4W is inserted directly after Q4. This makes `cas_n` low for two cycles. The two bits act independently, giving accesses of 5, 6 or 7 cycles. A wait cycle drives the same outputs as the cycle before it.
- R6: `dram_a` carries the row `addr[15:8]` in Q1, Q1W and Q2, and the column `addr[7:0]` in Q3 through Q5. It is 0 in idle.
- R7: On a write (`wr`=1), `we_n` is 0 and `dq_oe` is 1 with `dq_out` equal to the write byte from Q3 through the last column-strobe cycle. `rd_n` stays 1 throughout.
- R8: On a read (`wr`=0), `rd_n` is 0 from Q3 through the last column-strobe cycle. `we_n` stays 1 and `dq_oe` stays 0. `rdata` takes the `dq_in` value present in the last column-strobe cycle (Q4W if enabled, else Q4) and holds it until the next read.
- R9: A pulse of `cfg_wr` writes `cfg_rasw`/`cfg_casw` into the register of area `cfg_sel`. An access uses the register of `area` as it was when the access was accepted. Writes during an access do not change that access.
- R10: A request raised while `busy` is 1 is ignored. The running access keeps its captured address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for a stretch register |
| cfg_sel | input | 1 | Area whose register is written |
| cfg_rasw | input | 1 | Row stretch bit to write |
| cfg_casw | input | 1 | Column stretch bit to write |
| req | input | 1 | Access request, taken only in idle |
| wr | input | 1 | 1 = write, 0 = read |
| area | input | 1 | DRAM area of the request |
| addr | input | 16 | Byte address, row in upper half, column in lower half |
| wdata | input | 8 | Write byte |
| dq_in | input | 8 | Data bus input from DRAM |
| busy | output | 1 | Access in progress |
| dram_a | output | 8 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus output to DRAM |
| dq_oe | output | 1 | Data bus output enable |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
A wrong phase state shows at the strobe pins in the same cycle: the strobe shape or the address half is wrong, or the access has the wrong number of cycles. The bench compares every output in every cycle of an access against a trace computed from the stretch bits. A mistaken snapshot of the stretch bits or of the request shows within the first two cycles, as a missing or extra wait phase or as a wrong address. A capture taken in the wrong cycle shows in `rdata` one cycle after `done`, because the bench presents a fresh random byte on `dq_in` in every cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_Q1   = 3'd1,
        S_Q1W  = 3'd2,
        S_Q2   = 3'd3,
        S_Q3   = 3'd4,
        S_Q4   = 3'd5,
        S_Q4W  = 3'd6,
        S_Q5   = 3'd7
    } phase_t;

    typedef struct packed {
        logic ras_ext;
        logic cas_ext;
    } stretch_t;

endpackage

// File: rtl/dram_stretch_regs.sv
module dram_stretch_regs
    import dram_seq_pkg::*;
#(
    parameter int N_AREA = 2,
    localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AREA_W-1:0] wr_sel,
    input  stretch_t          wr_bits,
    input  logic [AREA_W-1:0] rd_sel,
    output stretch_t          rd_bits
);

    stretch_t regs [N_AREA];

    for (genvar g = 0; g < N_AREA; g++) begin : g_area
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_sel == AREA_W'(g))) begin
                regs[g] <= wr_bits;
            end
        end
    end

    assign rd_bits = regs[rd_sel];

endmodule

// File: rtl/dram_phase_fsm.sv
module dram_phase_fsm
    import dram_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  stretch_t ext_in,
    output phase_t   state,
    output logic     last_cas
);

    phase_t   nxt;
    stretch_t ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ext_q <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                ext_q <= ext_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: nxt = start ? S_Q1 : S_IDLE;
            S_Q1:   nxt = ext_q.ras_ext ? S_Q1W : S_Q2;
            S_Q1W:  nxt = S_Q2;
            S_Q2:   nxt = S_Q3;
            S_Q3:   nxt = S_Q4;
            S_Q4:   nxt = ext_q.cas_ext ? S_Q4W : S_Q5;
            S_Q4W:  nxt = S_Q5;
            S_Q5:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign last_cas = (state == S_Q4W) || ((state == S_Q4) && !ext_q.cas_ext);

    // R2: the final phase always returns to idle
    assert_q5_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Q5) |=> (state == S_IDLE));

    // R4: the row wait phase only ever follows Q1
    assert_q1w_after_q1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Q1W) |-> ($past(state) == S_Q1));

    // R5: the column wait phase only ever follows Q4
    assert_q4w_after_q4_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Q4W) |-> ($past(state) == S_Q4));

    // R10: a new access starts only out of idle
    assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Q1) |-> ($past(state) == S_IDLE));

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            state,
    input  logic              start,
    input  logic              last_cas,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [MUX_W-1:0]  dram_a,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [MUX_W-1:0]  row_a;
    logic [MUX_W-1:0]  col_a;
    logic              data_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                wr_q    <= wr_in;
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (last_cas && !wr_q) begin
                rdata <= dq_in;
            end
        end
    end

    assign row_a = MUX_W'(addr_q[ADDR_W-1:COL_W]);
    assign col_a = MUX_W'(addr_q[COL_W-1:0]);

    always_comb begin
        dram_a  = '0;
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        data_ph = 1'b0;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_Q1, S_Q1W: begin
                dram_a = row_a;
            end
            S_Q2: begin
                dram_a = row_a;
                ras_n  = 1'b0;
            end
            S_Q3: begin
                dram_a  = col_a;
                ras_n   = 1'b0;
                data_ph = 1'b1;
            end
            S_Q4, S_Q4W: begin
                dram_a  = col_a;
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                data_ph = 1'b1;
            end
            S_Q5: begin
                dram_a = col_a;
                done   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign we_n   = !(data_ph && wr_q);
    assign rd_n   = !(data_ph && !wr_q);
    assign dq_oe  = data_ph && wr_q;
    assign dq_out = dq_oe ? wdata_q : '0;

    // R7: read and write strobes are never active together
    assert_rd_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n));

    // R7: the data bus is driven only while writing
    assert_oe_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n);

    // R3: the column strobe is only active while the row strobe is active
    assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int DATA_W = 8,
    parameter int N_AREA = 2,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [AREA_W-1:0] cfg_sel,
    input  logic              cfg_rasw,
    input  logic              cfg_casw,
    input  logic              req,
    input  logic              wr,
    input  logic [AREA_W-1:0] area,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              busy,
    output logic [MUX_W-1:0]  dram_a,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    phase_t   state;
    stretch_t sel_bits;
    stretch_t wr_bits;
    logic     start;
    logic     last_cas;

    assign wr_bits = '{ras_ext: cfg_rasw, cas_ext: cfg_casw};
    assign start   = req && (state == S_IDLE);
    assign busy    = (state != S_IDLE);

    dram_stretch_regs #(.N_AREA(N_AREA)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_bits (wr_bits),
        .rd_sel  (area),
        .rd_bits (sel_bits)
    );

    dram_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ext_in   (sel_bits),
        .state    (state),
        .last_cas (last_cas)
    );

    dram_pin_drive #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .start    (start),
        .last_cas (last_cas),
        .wr_in    (wr),
        .addr_in  (addr),
        .wdata_in (wdata),
        .dq_in    (dq_in),
        .dram_a   (dram_a),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .rd_n     (rd_n),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .rdata    (rdata),
        .done     (done)
    );

    // R3: the row strobe rises only in the completion cycle
    assert_ras_rise_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> done);

    // R2: done is a single-cycle pulse followed by idle
    assert_done_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/test_dram_seq.sv
module test_dram_seq;

    localparam int B_Q1 = 1, B_Q1W = 2, B_Q2 = 3, B_Q3 = 4, B_Q4 = 5, B_Q4W = 6, B_Q5 = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0, cfg_rasw = 1'b0, cfg_casw = 1'b0;
    logic        req = 1'b0, wr = 1'b0, area = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, dq_in = '0;
    logic        busy, ras_n, cas_n, we_n, rd_n, dq_oe, done;
    logic [7:0]  dram_a, dq_out, rdata;

    int checks = 0;
    int errors = 0;
    bit model_r [2];
    bit model_c [2];

    always #5 clk = ~clk;

    dram_seq i_dram_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_rasw(cfg_rasw), .cfg_casw(cfg_casw), .req(req), .wr(wr),
        .area(area), .addr(addr), .wdata(wdata), .dq_in(dq_in),
        .busy(busy), .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .rd_n(rd_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .rdata(rdata), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int phase_at(input int k, input bit r, input bit c);
        int p = k;
        if (p == 1) return B_Q1;
        if (r) begin
            if (p == 2) return B_Q1W;
            p--;
        end
        if (p == 2) return B_Q2;
        if (p == 3) return B_Q3;
        if (p == 4) return B_Q4;
        if (c) begin
            if (p == 5) return B_Q4W;
            p--;
        end
        return B_Q5;
    endfunction

    task automatic cfg_write(input bit a, input bit r, input bit c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = a; cfg_rasw = r; cfg_casw = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_r[a] = r; model_c[a] = c;
    endtask

    task automatic do_access(input bit w, input bit a, input logic [15:0] ad,
                             input logic [7:0] wd, input bit disturb);
        bit r = model_r[a];
        bit c = model_c[a];
        int n = 5 + int'(r) + int'(c);
        logic [7:0] cap = '0;
        logic [7:0] row = ad[15:8];
        logic [7:0] col = ad[7:0];
        @(negedge clk);
        req = 1'b1; wr = w; area = a; addr = ad; wdata = wd;
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= n; k++) begin
            int ph = phase_at(k, r, c);
            bit dph = (ph == B_Q3) || (ph == B_Q4) || (ph == B_Q4W);
            bit e_ras = (ph == B_Q1) || (ph == B_Q1W) || (ph == B_Q5);
            bit e_cas = !((ph == B_Q4) || (ph == B_Q4W));
            logic [7:0] e_a = (ph <= B_Q2) ? row : col;
            if (k > 1) @(negedge clk);
            dq_in = 8'($urandom);
            if (k == n - 1) cap = dq_in;
            if (disturb && k == 2) begin
                req = 1'b1; wr = ~w; addr = ~ad; wdata = ~wd;
                cfg_wr = 1'b1; cfg_sel = a; cfg_rasw = ~r; cfg_casw = ~c;
            end
            if (disturb && k == 3) begin
                req = 1'b0; cfg_wr = 1'b0;
            end
            chk(ras_n == e_ras, r ? "R4 ras_n" : "R3 ras_n", int'(ras_n), int'(e_ras));
            chk(cas_n == e_cas, c ? "R5 cas_n" : "R3 cas_n", int'(cas_n), int'(e_cas));
            chk(dram_a == e_a, disturb ? "R10 dram_a" : "R6 dram_a", int'(dram_a), int'(e_a));
            chk(done == (ph == B_Q5), "R2 done", int'(done), int'(ph == B_Q5));
            chk(busy == 1'b1, "R2 busy", int'(busy), 1);
            if (w) begin
                chk(we_n == !dph, "R7 we_n", int'(we_n), int'(!dph));
                chk(rd_n == 1'b1, "R7 rd_n", int'(rd_n), 1);
                chk(dq_oe == dph, "R7 dq_oe", int'(dq_oe), int'(dph));
                if (dph) chk(dq_out == wd, "R7 dq_out", int'(dq_out), int'(wd));
            end else begin
                chk(rd_n == !dph, "R8 rd_n", int'(rd_n), int'(!dph));
                chk(we_n == 1'b1, "R8 we_n", int'(we_n), 1);
                chk(dq_oe == 1'b0, "R8 dq_oe", int'(dq_oe), 0);
            end
        end
        if (disturb) begin
            model_r[a] = ~r; model_c[a] = ~c;
        end
        @(negedge clk);
        chk(busy == 1'b0, "R2 idle after Q5", int'(busy), 0);
        chk(done == 1'b0, "R2 done low", int'(done), 0);
        if (!w) chk(rdata == cap, c ? "R8 R5 rdata" : "R8 rdata", int'(rdata), int'(cap));
    endtask

    initial begin
        void'($urandom(32'd5150));
        model_r = '{0, 0}; model_c = '{0, 0};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
        chk({ras_n, cas_n, we_n, rd_n} == 4'hF, "R1 strobes", int'({ras_n, cas_n, we_n, rd_n}), 15);
        chk(dq_oe == 1'b0 && rdata == 8'h00, "R1 data", int'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && dram_a == 8'h00, "R1 idle after release", int'(dram_a), 0);

        // directed corner cases
        do_access(1'b0, 1'b0, 16'hA55A, 8'h00, 1'b0);   // R2 plain read
        cfg_write(1'b1, 1'b1, 1'b1);                     // R9 area 1 both stretches
        do_access(1'b1, 1'b1, 16'h3C81, 8'hE7, 1'b0);   // R4 R5 write 7 cycles
        do_access(1'b0, 1'b0, 16'h0102, 8'h00, 1'b0);   // R9 area 0 still plain
        cfg_write(1'b0, 1'b1, 1'b0);
        do_access(1'b0, 1'b0, 16'hFF00, 8'h00, 1'b0);   // R4 alone
        cfg_write(1'b0, 1'b0, 1'b1);
        do_access(1'b1, 1'b0, 16'h00FF, 8'h5A, 1'b0);   // R5 alone write
        do_access(1'b0, 1'b0, 16'h1234, 8'h00, 1'b1);   // R10 R9 disturb mid access
        do_access(1'b0, 1'b0, 16'h4321, 8'h00, 1'b0);   // R9 new bits now apply

        // random mix
        for (int i = 0; i < 60; i++) begin
            if (($urandom % 3) == 0)
                cfg_write(1'($urandom), 1'($urandom), 1'($urandom));
            do_access(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom),
                      (($urandom % 5) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule